// File: doc/BRIEF.md
# Extended Hamming Single-Correct Double-Detect Codec (32-bit)

This block protects a 32-bit word with a 39-bit extended Hamming codeword. It has two independent combinational halves. The encoder turns a data word into a codeword. The decoder takes a codeword that may be damaged and returns the data word together with a three-way verdict. The verdict says the word came back unmodified, that a single flipped bit was repaired, or that the damage could not be repaired.

The codeword is a 38-position Hamming code with one overall parity bit after it. Position p of the codeword sits on vector bit p-1. The decoder computes a 6-bit syndrome and an overall parity result. From these two values it settles the outcome without any clock or storage, so a user places it directly in the write path and the read path of a memory or register array.

Damage to three or more bits lies outside the code's guarantee. Such patterns can be reported as clean, as corrected, or as invalid.

Top module: `hamming_secded_codec`

## Requirements
- R1: The codeword layout is fixed. The 32 data bits fill the non-power-of-two positions 3, 5, 6, 7, 9 through 15, 17 through 31 and 33 through 38 in ascending order, with data bit 0 at position 3. The check bits sit at positions 1, 2, 4, 8, 16 and 32. The overall parity bit sits at position 39. Position p is carried on vector bit p-1.
- R2: The check bit at position 2^k equals the XOR of every other position in 1..38 whose index has bit k set.
- R3: Every codeword produced by the encoder has even parity over all 39 bits.
- R4: The decoder status is 2'b00 for clean, 2'b01 for corrected and 2'b10 for invalid. The value 2'b11 never appears.
- R5: An undamaged codeword decodes to its original data with status clean.
- R6: A codeword with exactly one flipped bit at any position from 1 to 38 decodes to the original data with status corrected.
- R7: A codeword whose only flipped bit is the overall parity bit (position 39) decodes to the original data with status corrected.
- R8: A codeword with any two flipped bits decodes with status invalid. The data output then carries the data positions of the received codeword unchanged.
- R9: A received codeword with a syndrome above 38 and odd overall parity decodes with status invalid. The data output then carries the data positions of the received codeword unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 32 | Data word to be encoded |
| enc_code_o | output | 39 | Codeword for enc_data_i, position p on bit p-1 |
| dec_code_i | input | 39 | Received codeword, possibly damaged |
| dec_data_o | output | 32 | Repaired or passed-through data word |
| dec_status_o | output | 2 | Verdict: 00 clean, 01 corrected, 10 invalid |

## Verification
The hardest verdict to reach from the ports is invalid because of an out-of-range syndrome. No single or double flip can produce it: a single flip always points inside positions 1..39, and a double flip always leaves the overall parity even. The stimulus reaches it by flipping three chosen positions whose indices XOR to 39 or 63, for example positions 32, 4 and 3. This is done on top of the full sweeps of every single and every double flip over a set of edge-case and pseudo-random data words.

// File: rtl/ham_pkg.sv
package ham_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 6;
    localparam int HAM_N  = DATA_W + CHK_W;
    localparam int CW_W   = HAM_N + 1;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'b00,
        ST_CORRECTED = 2'b01,
        ST_INVALID   = 2'b10
    } dec_status_e;

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Data bit index carried at a non-power-of-two position.
    function automatic int data_index(input int p);
        int n;
        n = 0;
        for (int q = 1; q < p; q++) begin
            if (!is_pow2(q)) n++;
        end
        return n;
    endfunction

    // Positions (as vector bits) covered by the check bit of weight 2^k.
    function automatic logic [HAM_N-1:0] cover_mask(input int k);
        logic [HAM_N-1:0] m;
        m = '0;
        for (int p = 1; p <= HAM_N; p++) begin
            if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ham_encoder.sv
module ham_encoder
    import ham_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int C_W = CHK_W,
    localparam int N_W = D_W + C_W
) (
    input  logic [D_W-1:0] data_i,
    output logic [N_W:0]   code_o
);

    logic [N_W-1:0] placed;
    logic [C_W-1:0] chk;

    // Scatter data into non-power-of-two positions.
    for (genvar p = 1; p <= N_W; p++) begin : g_place
        if (is_pow2(p)) begin : g_hole
            assign placed[p-1] = 1'b0;
        end else begin : g_dat
            localparam int DI = data_index(p);
            assign placed[p-1] = data_i[DI];
        end
    end

    for (genvar k = 0; k < C_W; k++) begin : g_chk
        localparam logic [N_W-1:0] MASK = N_W'(cover_mask(k));
        assign chk[k] = ^(placed & MASK);
    end

    logic [N_W-1:0] body;
    for (genvar p = 1; p <= N_W; p++) begin : g_body
        if (is_pow2(p)) begin : g_c
            localparam int K = $clog2(p);
            assign body[p-1] = chk[K];
        end else begin : g_d
            assign body[p-1] = placed[p-1];
        end
    end

    assign code_o = {^body, body};

endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome
    import ham_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int C_W = CHK_W,
    localparam int N_W = D_W + C_W
) (
    input  logic [N_W:0]   code_i,
    output logic [C_W-1:0] syn_o,
    output logic           par_err_o
);

    for (genvar k = 0; k < C_W; k++) begin : g_syn
        localparam logic [N_W-1:0] MASK = N_W'(cover_mask(k));
        assign syn_o[k] = ^(code_i[N_W-1:0] & MASK);
    end

    assign par_err_o = ^code_i;

endmodule

// File: rtl/ham_corrector.sv
module ham_corrector
    import ham_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int C_W = CHK_W,
    localparam int N_W = D_W + C_W
) (
    input  logic [N_W:0]   code_i,
    input  logic [C_W-1:0] syn_i,
    input  logic           par_err_i,
    output logic [D_W-1:0] data_o,
    output dec_status_e    status_o
);

    logic syn_zero;
    logic in_range;
    logic do_fix;
    logic [N_W-1:0] flip;
    logic [N_W-1:0] fixed;

    assign syn_zero = (syn_i == '0);
    assign in_range = (int'(syn_i) <= N_W);
    assign do_fix   = par_err_i && !syn_zero && in_range;

    for (genvar p = 1; p <= N_W; p++) begin : g_flip
        assign flip[p-1] = do_fix && (syn_i == C_W'(p));
    end

    assign fixed = code_i[N_W-1:0] ^ flip;

    for (genvar p = 1; p <= N_W; p++) begin : g_gather
        if (!is_pow2(p)) begin : g_d
            localparam int DI = data_index(p);
            assign data_o[DI] = fixed[p-1];
        end
    end

    always_comb begin
        unique case ({syn_zero, par_err_i})
            2'b10:   status_o = ST_CLEAN;
            2'b11:   status_o = ST_CORRECTED;
            2'b01:   status_o = in_range ? ST_CORRECTED : ST_INVALID;
            default: status_o = ST_INVALID;
        endcase
    end

endmodule

// File: rtl/hamming_secded_codec.sv
module hamming_secded_codec
    import ham_pkg::*;
(
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CW_W-1:0]   enc_code_o,
    input  logic [CW_W-1:0]   dec_code_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [1:0]        dec_status_o
);

    logic [CHK_W-1:0] syn;
    logic             par_err;
    dec_status_e      status;

    ham_encoder #(.D_W(DATA_W), .C_W(CHK_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_o)
    );

    ham_syndrome #(.D_W(DATA_W), .C_W(CHK_W)) u_syn (
        .code_i    (dec_code_i),
        .syn_o     (syn),
        .par_err_o (par_err)
    );

    ham_corrector #(.D_W(DATA_W), .C_W(CHK_W)) u_cor (
        .code_i    (dec_code_i),
        .syn_i     (syn),
        .par_err_i (par_err),
        .data_o    (dec_data_o),
        .status_o  (status)
    );

    assign dec_status_o = status;

endmodule

// File: rtl/hamming_secded_checker.sv
module hamming_secded_checker
    import ham_pkg::*;
(
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CW_W-1:0]   enc_code_o,
    input logic [CW_W-1:0]   dec_code_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [1:0]        dec_status_o
);

    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] enc_back;

    for (genvar p = 1; p <= HAM_N; p++) begin : g_raw
        if (!is_pow2(p)) begin : g_d
            localparam int DI = data_index(p);
            assign raw[DI]      = dec_code_i[p-1];
            assign enc_back[DI] = enc_code_o[p-1];
        end
    end

    always_comb begin
        p_even_parity_r3: assert (^enc_code_o == 1'b0);
        p_data_placed_r1: assert (enc_back == enc_data_i);
        p_status_legal_r4: assert (dec_status_o != 2'b11);
        if (dec_status_o == 2'b00) begin
            p_clean_pass_r5: assert (dec_data_o == raw);
        end
        if (dec_status_o == 2'b01) begin
            p_single_fix_r6: assert ($countones(dec_data_o ^ raw) <= 1);
        end
        if (dec_status_o == 2'b10) begin
            p_invalid_raw_r8: assert (dec_data_o == raw);
        end
    end

endmodule

bind hamming_secded_codec hamming_secded_checker u_chk (
    .enc_data_i   (enc_data_i),
    .enc_code_o   (enc_code_o),
    .dec_code_i   (dec_code_i),
    .dec_data_o   (dec_data_o),
    .dec_status_o (dec_status_o)
);

// File: tb/hamming_secded_codec_tb.sv
`timescale 1ns/1ps
module hamming_secded_codec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] enc_data_i = '0;
    logic [38:0] enc_code_o;
    logic [38:0] dec_code_i = '0;
    logic [31:0] dec_data_o;
    logic [1:0]  dec_status_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hamming_secded_codec u_dut (
        .enc_data_i   (enc_data_i),
        .enc_code_o   (enc_code_o),
        .dec_code_i   (dec_code_i),
        .dec_data_o   (dec_data_o),
        .dec_status_o (dec_status_o)
    );

    function automatic logic [38:0] m_enc(input logic [31:0] d);
        logic [38:0] c;
        int j;
        logic b;
        c = '0;
        j = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p-1] = d[j];
                j++;
            end
        end
        for (int k = 0; k < 6; k++) begin
            b = 1'b0;
            for (int p = 1; p <= 38; p++)
                if (((p >> k) & 1) == 1) b ^= c[p-1];
            c[(1 << k) - 1] = b;
        end
        c[38] = ^c[37:0];
        return c;
    endfunction

    function automatic logic [31:0] m_ext(input logic [38:0] c);
        logic [31:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[j] = c[p-1];
                j++;
            end
        end
        return d;
    endfunction

    task automatic chk_dec(input logic [38:0] code, input logic [31:0] exp_d,
                           input logic [1:0] exp_s, input string req);
        dec_code_i = code;
        #2;
        total++;
        if (dec_data_o !== exp_d || dec_status_o !== exp_s) begin
            bad++;
            $display("FAIL %s code=%h data=%h status=%0d expected data=%h status=%0d",
                     req, code, dec_data_o, dec_status_o, exp_d, exp_s);
        end
    endtask

    task automatic chk_enc(input logic [31:0] d);
        logic [38:0] e;
        e = m_enc(d);
        enc_data_i = d;
        #2;
        total++;
        if (enc_code_o !== e) begin
            bad++;
            $display("FAIL R1/R2 data=%h code=%h expected %h", d, enc_code_o, e);
        end
        total++;
        if (^enc_code_o !== 1'b0) begin
            bad++;
            $display("FAIL R3 data=%h parity=%b expected 0", d, ^enc_code_o);
        end
    endtask

    task automatic sweep_word(input logic [31:0] d, input bit with_doubles);
        logic [38:0] c;
        logic [38:0] t;
        chk_enc(d);
        c = m_enc(d);
        // R5 clean, R4 legal status
        chk_dec(c, d, 2'b00, "R5");
        total++;
        if (dec_status_o == 2'b11) begin
            bad++;
            $display("FAIL R4 status=%0d expected not 3", dec_status_o);
        end
        // R6 / R7 singles
        for (int p = 1; p <= 39; p++) begin
            t = c;
            t[p-1] = ~t[p-1];
            chk_dec(t, d, 2'b01, (p == 39) ? "R7" : "R6");
        end
        // R8 doubles
        if (with_doubles) begin
            for (int a = 1; a <= 39; a++) begin
                for (int b = a + 1; b <= 39; b++) begin
                    t = c;
                    t[a-1] = ~t[a-1];
                    t[b-1] = ~t[b-1];
                    chk_dec(t, m_ext(t), 2'b10, "R8");
                end
            end
        end
        // R9 triples with syndrome 39 and 63
        t = c;
        t[31] = ~t[31]; t[3] = ~t[3]; t[2] = ~t[2];
        chk_dec(t, m_ext(t), 2'b10, "R9");
        t = c;
        t[31] = ~t[31]; t[15] = ~t[15]; t[14] = ~t[14];
        chk_dec(t, m_ext(t), 2'b10, "R9");
    endtask

    initial begin : wdog
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                bad++;
                total++;
                $display("FAIL watchdog expired");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] lcg;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state with all-zero inputs: R5
        chk_dec('0, '0, 2'b00, "R5");
        total++;
        if (enc_code_o !== '0) begin
            bad++;
            $display("FAIL R1 zero code=%h expected 0", enc_code_o);
        end
        sweep_word(32'h0000_0000, 1);
        sweep_word(32'hFFFF_FFFF, 1);
        sweep_word(32'hA5A5_A5A5, 1);
        for (int i = 0; i < 32; i++) sweep_word(32'h1 << i, (i % 4) == 0);
        lcg = 32'h1234_5678;
        for (int i = 0; i < 8; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            sweep_word(lcg, 1);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule